// File: doc/BRIEF.md
# Shared Address Translation Buffer

This block is a fully associative buffer of address translations that serves both the instruction side and the data side of a core. Each of its 48 slots maps a pair of neighbouring virtual pages, one even and one odd, onto two independent physical frames, so the buffer covers 96 pages at most. A per-slot size code sets the page size anywhere from 4 KB to 16 MB in factor-of-four steps. The size code sets which low virtual page bits drop out of the compare, which address bit chooses the even or odd half, and how many low address bits pass straight through to the physical address.

A lookup presents a 32-bit virtual address, an 8-bit address-space tag and a store flag. One clock later the block returns exactly one of four outcomes: a good translation with its physical address and cache attribute, a miss, an invalid-page fault or a write-protection fault. Software-style maintenance goes through the same block. An indexed write loads a slot, an indexed read returns a slot one cycle later, and a probe searches all slots for an address and tag and reports the slot that matches. Slot contents change on the clock edge after a write, so a lookup in the same cycle as a write still sees the old contents.

Top module: `jtlb`

## Requirements
- R1: After reset every slot holds all zeros and rs_vld, rd_vld and pb_vld are low.
- R2: A slot word is 89 bits. The even half occupies bits 28:0 and the odd half bits 57:29. Within a half, bits 2:0 are the cache attribute, bit 3 is writable, bit 4 is valid and bits 28:5 are the frame number. Above the halves, bits 60:58 are the size code, bit 61 is global, bits 69:62 are the address-space tag and bits 88:70 are the virtual pair number. A write with wr_en at wr_idx below 48 stores wr_entry. A read with rd_en raises rd_vld in the next cycle, with rd_entry equal to that slot.
- R3: A lookup with lk_req raises rs_vld in the next cycle. In that cycle exactly one of rs_ok, rs_miss, rs_inval and rs_mod is high. rs_pa and rs_attr are zero unless rs_ok is high.
- R4: For size code s (0 to 6, meaning 4 KB times 4^s), the low 2s bits of the virtual pair number (lk_va[31:13]) are not compared. lk_va bit 12+2s picks the odd half when it is 1. The low 12+2s bits of rs_pa come from lk_va, and the upper bits come from {frame, 12'b0}.
- R5: A slot matches only when its address-space tag equals lk_asid or its global bit is set.
- R6: When no slot matches, rs_miss is set.
- R7: A match whose selected half has valid clear sets rs_inval.
- R8: A store that matches a valid half whose writable bit is clear sets rs_mod. A load to the same half gives rs_ok.
- R9: When several slots match, the lowest slot index wins.
- R10: A probe with pb_en raises pb_vld in the next cycle. pb_idx is the lowest matching slot, or pb_fail is set with pb_idx zero when nothing matches.
- R11: A lookup issued in the same cycle as a write uses the slot contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space tag |
| lk_store | input | 1 | Lookup is a store |
| rs_vld | output | 1 | Lookup result valid |
| rs_ok | output | 1 | Translation good |
| rs_miss | output | 1 | No slot matched |
| rs_inval | output | 1 | Matched half invalid |
| rs_mod | output | 1 | Store to write-protected half |
| rs_pa | output | 36 | Physical address |
| rs_attr | output | 3 | Cache attribute |
| wr_en | input | 1 | Indexed write |
| wr_idx | input | 6 | Write slot index |
| wr_entry | input | 89 | Slot word to write |
| rd_en | input | 1 | Indexed read |
| rd_idx | input | 6 | Read slot index |
| rd_vld | output | 1 | Read data valid |
| rd_entry | output | 89 | Slot word read |
| pb_en | input | 1 | Probe request |
| pb_va | input | 32 | Probe virtual address |
| pb_asid | input | 8 | Probe address-space tag |
| pb_vld | output | 1 | Probe result valid |
| pb_fail | output | 1 | Probe found no match |
| pb_idx | output | 6 | Matching slot index |

## Verification
The cases that are hardest to reach from the ports are overlapping slots and the same-cycle write-and-lookup race. Neither occurs unless the stimulus builds it on purpose. For the overlap, the bench loads two slots with the same pair number and tag, writing the higher index first, then checks that both lookup and probe resolve to the lower one. For the race, the bench issues a write and a lookup of that same address on one clock edge, expects a miss, and then expects a hit on the next lookup. The large-page cases use addresses whose ignored pair bits are nonzero, and frames whose low bits are nonzero, so that a wrong mask shows up in rs_pa.

// File: rtl/jtlb_pkg.sv
package jtlb_pkg;
    localparam int VA_W   = 32;
    localparam int OFS_W  = 12;
    localparam int VPN2_W = VA_W - OFS_W - 1;
    localparam int ASID_W = 8;
    localparam int PFN_W  = 24;
    localparam int PA_W   = PFN_W + OFS_W;
    localparam int SZ_W   = 3;
    localparam int ATTR_W = 3;
    localparam int MAX_SZ = 6;

    typedef struct packed {
        logic [PFN_W-1:0]  pfn;
        logic              valid;
        logic              wr;
        logic [ATTR_W-1:0] attr;
    } half_t;

    typedef struct packed {
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic [SZ_W-1:0]   sz;
        half_t             odd;
        half_t             even;
    } entry_t;

    localparam int ENT_W = $bits(entry_t);

    function automatic logic [SZ_W-1:0] clamp_sz(input logic [SZ_W-1:0] s);
        return (int'(s) > MAX_SZ) ? SZ_W'(MAX_SZ) : s;
    endfunction

    // bits of the pair number left out of the compare
    function automatic logic [VPN2_W-1:0] ign_mask(input logic [SZ_W-1:0] s);
        logic [63:0] m;
        m = (64'd1 << (2 * int'(s))) - 64'd1;
        return m[VPN2_W-1:0];
    endfunction
endpackage

// File: rtl/jtlb_match.sv
module jtlb_match
    import jtlb_pkg::*;
#(
    parameter int ENTRIES = 48,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  entry_t [ENTRIES-1:0] tbl,
    input  logic [VA_W-1:0]      va,
    input  logic [ASID_W-1:0]    asid,
    output logic                 hit,
    output logic [IDX_W-1:0]     idx
);
    logic [ENTRIES-1:0] hitv;
    logic [VPN2_W-1:0]  vpn2;

    assign vpn2 = va[VA_W-1:OFS_W+1];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        logic [SZ_W-1:0] s;
        logic            tag_ok;
        assign s       = clamp_sz(tbl[i].sz);
        assign tag_ok  = tbl[i].glob || (tbl[i].asid == asid);
        assign hitv[i] = tag_ok && (((tbl[i].vpn2 ^ vpn2) & ~ign_mask(s)) == '0);
    end

    // lowest index wins
    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hitv[i]) idx = IDX_W'(i);
        end
    end

    assign hit = |hitv;
endmodule

// File: rtl/jtlb_xlate.sv
module jtlb_xlate
    import jtlb_pkg::*;
(
    input  entry_t            ent,
    input  logic              hit,
    input  logic [VA_W-1:0]   va,
    input  logic              store,
    output logic              ok,
    output logic              miss,
    output logic              inval,
    output logic              modf,
    output logic [PA_W-1:0]   pa,
    output logic [ATTR_W-1:0] attr
);
    logic [SZ_W-1:0] s;
    logic            odd_sel;
    half_t           h;
    logic [PA_W-1:0] offm;
    logic [63:0]     offm_w;

    assign s       = clamp_sz(ent.sz);
    assign odd_sel = va[OFS_W + 2 * int'(s)];
    assign h       = odd_sel ? ent.odd : ent.even;
    assign offm_w  = (64'd1 << (OFS_W + 2 * int'(s))) - 64'd1;
    assign offm    = offm_w[PA_W-1:0];

    assign miss  = !hit;
    assign inval = hit && !h.valid;
    assign modf  = hit && h.valid && store && !h.wr;
    assign ok    = hit && h.valid && !(store && !h.wr);
    assign pa    = ok ? (({h.pfn, {OFS_W{1'b0}}} & ~offm) | (PA_W'(va) & offm)) : '0;
    assign attr  = ok ? h.attr : '0;
endmodule

// File: rtl/jtlb.sv
module jtlb
    import jtlb_pkg::*;
#(
    parameter int ENTRIES = 48,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_store,
    output logic              rs_vld,
    output logic              rs_ok,
    output logic              rs_miss,
    output logic              rs_inval,
    output logic              rs_mod,
    output logic [PA_W-1:0]   rs_pa,
    output logic [ATTR_W-1:0] rs_attr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ENT_W-1:0]  wr_entry,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_vld,
    output logic [ENT_W-1:0]  rd_entry,
    input  logic              pb_en,
    input  logic [VA_W-1:0]   pb_va,
    input  logic [ASID_W-1:0] pb_asid,
    output logic              pb_vld,
    output logic              pb_fail,
    output logic [IDX_W-1:0]  pb_idx
);
    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(ENTRIES);

    typedef struct packed {
        entry_t [ENTRIES-1:0] tbl;
        logic                 rs_vld;
        logic                 rs_ok;
        logic                 rs_miss;
        logic                 rs_inval;
        logic                 rs_mod;
        logic [PA_W-1:0]      rs_pa;
        logic [ATTR_W-1:0]    rs_attr;
        logic                 rd_vld;
        logic [ENT_W-1:0]     rd_entry;
        logic                 pb_vld;
        logic                 pb_fail;
        logic [IDX_W-1:0]     pb_idx;
    } state_t;

    state_t state_d, state_q;

    logic              lk_hit, pb_hit;
    logic [IDX_W-1:0]  lk_sel, pb_sel;
    logic              x_ok, x_miss, x_inval, x_mod;
    logic [PA_W-1:0]   x_pa;
    logic [ATTR_W-1:0] x_attr;

    jtlb_match #(.ENTRIES(ENTRIES)) u_lk_match (
        .tbl (state_q.tbl),
        .va  (lk_va),
        .asid(lk_asid),
        .hit (lk_hit),
        .idx (lk_sel)
    );

    jtlb_match #(.ENTRIES(ENTRIES)) u_pb_match (
        .tbl (state_q.tbl),
        .va  (pb_va),
        .asid(pb_asid),
        .hit (pb_hit),
        .idx (pb_sel)
    );

    jtlb_xlate u_xlate (
        .ent  (state_q.tbl[lk_sel]),
        .hit  (lk_hit),
        .va   (lk_va),
        .store(lk_store),
        .ok   (x_ok),
        .miss (x_miss),
        .inval(x_inval),
        .modf (x_mod),
        .pa   (x_pa),
        .attr (x_attr)
    );

    always_comb begin
        state_d = state_q;

        state_d.rs_vld   = lk_req;
        state_d.rs_ok    = lk_req && x_ok;
        state_d.rs_miss  = lk_req && x_miss;
        state_d.rs_inval = lk_req && x_inval;
        state_d.rs_mod   = lk_req && x_mod;
        state_d.rs_pa    = lk_req ? x_pa   : '0;
        state_d.rs_attr  = lk_req ? x_attr : '0;

        state_d.rd_vld = rd_en;
        if (rd_en) begin
            state_d.rd_entry = ({1'b0, rd_idx} < LIMIT) ? state_q.tbl[rd_idx] : '0;
        end

        state_d.pb_vld = pb_en;
        if (pb_en) begin
            state_d.pb_fail = !pb_hit;
            state_d.pb_idx  = pb_hit ? pb_sel : '0;
        end

        if (wr_en && ({1'b0, wr_idx} < LIMIT)) begin
            state_d.tbl[wr_idx] = entry_t'(wr_entry);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rs_vld   = state_q.rs_vld;
    assign rs_ok    = state_q.rs_ok;
    assign rs_miss  = state_q.rs_miss;
    assign rs_inval = state_q.rs_inval;
    assign rs_mod   = state_q.rs_mod;
    assign rs_pa    = state_q.rs_pa;
    assign rs_attr  = state_q.rs_attr;
    assign rd_vld   = state_q.rd_vld;
    assign rd_entry = state_q.rd_entry;
    assign pb_vld   = state_q.pb_vld;
    assign pb_fail  = state_q.pb_fail;
    assign pb_idx   = state_q.pb_idx;
endmodule

// File: rtl/jtlb_chk.sv
module jtlb_chk #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_req,
    input logic             rs_vld,
    input logic             rs_ok,
    input logic             rs_miss,
    input logic             rs_inval,
    input logic             rs_mod,
    input logic [35:0]      rs_pa,
    input logic [2:0]       rs_attr,
    input logic             rd_en,
    input logic             rd_vld,
    input logic             pb_en,
    input logic             pb_vld,
    input logic             pb_fail,
    input logic [IDX_W-1:0] pb_idx
);
    AST_LOOKUP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rs_vld);  // R3
    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rs_vld);  // R3
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rs_vld |-> $countones({rs_ok, rs_miss, rs_inval, rs_mod}) == 1);  // R3
    AST_PA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_vld && !rs_ok) |-> (rs_pa == '0 && rs_attr == '0));  // R3
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_vld);  // R2
    AST_PROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        pb_en |=> pb_vld);  // R10
    AST_PROBE_FAIL_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_vld && pb_fail) |-> pb_idx == '0);  // R10
endmodule

bind jtlb jtlb_chk #(.IDX_W(IDX_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_req  (lk_req),
    .rs_vld  (rs_vld),
    .rs_ok   (rs_ok),
    .rs_miss (rs_miss),
    .rs_inval(rs_inval),
    .rs_mod  (rs_mod),
    .rs_pa   (rs_pa),
    .rs_attr (rs_attr),
    .rd_en   (rd_en),
    .rd_vld  (rd_vld),
    .pb_en   (pb_en),
    .pb_vld  (pb_vld),
    .pb_fail (pb_fail),
    .pb_idx  (pb_idx)
);

// File: tb/jtlb_bench.sv
`timescale 1ns/1ps
module jtlb_bench;
    localparam int N = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_store = 1'b0;
    logic        rs_vld, rs_ok, rs_miss, rs_inval, rs_mod;
    logic [35:0] rs_pa;
    logic [2:0]  rs_attr;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [88:0] wr_entry = '0;
    logic        rd_en = 1'b0;
    logic [5:0]  rd_idx = '0;
    logic        rd_vld;
    logic [88:0] rd_entry;
    logic        pb_en = 1'b0;
    logic [31:0] pb_va = '0;
    logic [7:0]  pb_asid = '0;
    logic        pb_vld, pb_fail;
    logic [5:0]  pb_idx;

    always #2 clk = ~clk;

    jtlb u_jtlb (.*);

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;
    logic [88:0] model [N];
    logic [42:0] exp_q [$];
    string       tag_q [$];

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [28:0] mk_half(logic [23:0] pfn, logic v, logic w, logic [2:0] a);
        return {pfn, v, w, a};
    endfunction

    function automatic logic [88:0] mk_ent(logic [18:0] vpn2, logic [7:0] asid, logic g,
                                           logic [2:0] sz, logic [28:0] odd, logic [28:0] even);
        return {vpn2, asid, g, sz, odd, even};
    endfunction

    // expected {ok, miss, inval, mod, attr, pa}
    function automatic logic [42:0] predict(logic [31:0] va, logic [7:0] asid, logic st);
        for (int i = 0; i < N; i++) begin
            int          sz;
            logic [18:0] keep;
            sz   = int'(model[i][60:58]);
            keep = ~19'(((1 << (2 * sz)) - 1));
            if ((model[i][61] || model[i][69:62] == asid) &&
                ((model[i][88:70] & keep) == (va[31:13] & keep))) begin
                logic [28:0] h;
                logic [35:0] pa;
                h = va[12 + 2 * sz] ? model[i][57:29] : model[i][28:0];
                if (!h[4]) return {4'b0010, 3'b0, 36'b0};
                if (st && !h[3]) return {4'b0001, 3'b0, 36'b0};
                for (int b = 0; b < 36; b++) begin
                    if (b < 12 + 2 * sz) pa[b] = va[b];
                    else                 pa[b] = h[5 + b - 12];
                end
                return {4'b1000, h[2:0], pa};
            end
        end
        return {4'b0100, 3'b0, 36'b0};
    endfunction

    task automatic do_write(int idx, logic [88:0] e);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_entry = e;
        @(negedge clk);
        wr_en = 1'b0;
        model[idx] = e;
    endtask

    task automatic do_lookup(string req, logic [31:0] va, logic [7:0] asid, logic st);
        @(negedge clk);
        lk_req = 1'b1; lk_va = va; lk_asid = asid; lk_store = st;
        exp_q.push_back(predict(va, asid, st));
        tag_q.push_back(req);
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    task automatic do_read(string req, int idx, logic [88:0] exp);
        @(negedge clk);
        rd_en = 1'b1; rd_idx = 6'(idx);
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, {127'b0, rd_vld}, 128'd1);
        chk(req, 128'(rd_entry), 128'(exp));
    endtask

    task automatic do_probe(string req, logic [31:0] va, logic [7:0] asid, logic fail, int idx);
        @(negedge clk);
        pb_en = 1'b1; pb_va = va; pb_asid = asid;
        @(negedge clk);
        pb_en = 1'b0;
        chk(req, {120'b0, pb_vld, pb_fail, pb_idx}, {120'b0, 1'b1, fail, 6'(idx)});
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rs_vld) begin
            if (exp_q.size() == 0) begin
                chk("R3 unexpected", 128'(rs_vld), 128'd0);
            end else begin
                logic [42:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, 128'({rs_ok, rs_miss, rs_inval, rs_mod, rs_attr, rs_pa}), 128'(e));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 valids", {125'b0, rs_vld, rd_vld, pb_vld}, 128'd0);
        do_read("R1 slot clear", 5, '0);

        // R2: write and read back
        do_write(3, mk_ent(19'h12345, 8'd7, 1'b0, 3'd0,
                           mk_half(24'h011111, 1'b1, 1'b0, 3'd2),
                           mk_half(24'h0ABCDE, 1'b1, 1'b1, 3'd3)));
        do_read("R2 readback", 3, model[3]);

        // R3 basic translation, R8 write protection
        do_lookup("R3 even load", {19'h12345, 1'b0, 12'h5A4}, 8'd7, 1'b0);
        do_lookup("R3 even store", {19'h12345, 1'b0, 12'h001}, 8'd7, 1'b1);
        do_lookup("R8 odd store", {19'h12345, 1'b1, 12'hFFF}, 8'd7, 1'b1);
        do_lookup("R8 odd load", {19'h12345, 1'b1, 12'h010}, 8'd7, 1'b0);

        // R5/R6 tag matching
        do_lookup("R5 R6 tag mismatch", {19'h12345, 1'b0, 12'h5A4}, 8'd8, 1'b0);
        do_write(4, mk_ent(19'h00077, 8'd9, 1'b1, 3'd0,
                           mk_half(24'h0, 1'b0, 1'b0, 3'd0),
                           mk_half(24'h000222, 1'b1, 1'b1, 3'd5)));
        do_lookup("R5 global", {19'h00077, 1'b0, 12'h123}, 8'd200, 1'b0);
        do_lookup("R7 global odd invalid", {19'h00077, 1'b1, 12'h123}, 8'd200, 1'b0);
        do_lookup("R6 no slot", 32'hDEAD_0000, 8'd7, 1'b0);

        // R4 large pages
        do_write(5, mk_ent(19'h04000, 8'd7, 1'b0, 3'd2,
                           mk_half(24'h04001F, 1'b1, 1'b1, 3'd6),
                           mk_half(24'h030000, 1'b1, 1'b1, 3'd1)));
        do_lookup("R4 64K odd", (32'h04000 << 13) | 32'h0001_7ABC, 8'd7, 1'b0);
        do_lookup("R4 64K even", (32'h04000 << 13) | 32'h0000_EABC, 8'd7, 1'b0);
        do_write(12, mk_ent(19'h7F800, 8'd1, 1'b0, 3'd6,
                            mk_half(24'hF0FFFF, 1'b1, 1'b1, 3'd4),
                            mk_half(24'h100ABC, 1'b1, 1'b1, 3'd7)));
        do_lookup("R4 16M odd", 32'hFF12_3456, 8'd1, 1'b0);
        do_lookup("R4 16M even", 32'hFEAB_CDEF, 8'd1, 1'b0);

        // R7 invalid half
        do_write(6, mk_ent(19'h00200, 8'd7, 1'b0, 3'd0,
                           mk_half(24'h000555, 1'b1, 1'b1, 3'd0),
                           mk_half(24'h000444, 1'b0, 1'b1, 3'd0)));
        do_lookup("R7 invalid even", {19'h00200, 1'b0, 12'h0}, 8'd7, 1'b0);

        // R9 overlap: higher slot written first
        do_write(10, mk_ent(19'h00300, 8'd7, 1'b0, 3'd0,
                            mk_half(24'h0AAAAA, 1'b1, 1'b1, 3'd1),
                            mk_half(24'h0BBBBB, 1'b1, 1'b1, 3'd1)));
        do_write(2, mk_ent(19'h00300, 8'd7, 1'b0, 3'd0,
                           mk_half(24'h0CCCCC, 1'b1, 1'b1, 3'd2),
                           mk_half(24'h0DDDDD, 1'b1, 1'b1, 3'd2)));
        do_lookup("R9 lowest slot", {19'h00300, 1'b0, 12'h777}, 8'd7, 1'b0);

        // R10 probe
        do_probe("R10 R9 probe overlap", {19'h00300, 13'h0}, 8'd7, 1'b0, 2);
        do_probe("R10 probe large page", (32'h04000 << 13) | 32'h0001_0000, 8'd7, 1'b0, 5);
        do_probe("R10 probe fail", {19'h55555, 13'h0}, 8'd7, 1'b1, 0);

        // R11 write and lookup in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'd8;
        wr_entry = mk_ent(19'h00999, 8'd7, 1'b0, 3'd0,
                          mk_half(24'h000999, 1'b1, 1'b1, 3'd3),
                          mk_half(24'h000888, 1'b1, 1'b1, 3'd3));
        lk_req = 1'b1; lk_va = {19'h00999, 1'b0, 12'h042}; lk_asid = 8'd7; lk_store = 1'b0;
        exp_q.push_back(predict(lk_va, lk_asid, 1'b0));
        tag_q.push_back("R11 same cycle");
        model[8] = wr_entry;
        @(negedge clk);
        wr_en = 1'b0; lk_req = 1'b0;
        do_lookup("R11 after write", {19'h00999, 1'b0, 12'h042}, 8'd7, 1'b0);
        do_read("R2 slot 8", 8, model[8]);

        repeat (4) @(negedge clk);
        chk("R3 drained", 128'(exp_q.size()), 128'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule